// File: doc/BRIEF.md
# Cascaded Loss-Window Threshold Guard

This block watches a set of loss-measurement channels. Each channel delivers one new integrated sample on every strobe, and all channels share that strobe. For every channel the block keeps a ladder of running sums over integration windows that grow by a fixed factor from rung to rung. The shortest rung sums raw samples. Each longer rung sums the completed totals of the rung below it, and those totals are held in a short shift register. The longest rung therefore covers a very long span while storing only a few entries.

Each running sum is compared with a limit. The limit is picked by channel, by rung and by the current beam-energy index, and the limits live in a table that is filled through a write port. A channel that reaches its limit raises the unmaskable dump request. It also raises the maskable dump request, unless its bit in the channel mask is set. A dump request stays latched until reset. Each request leaves the block as a square wave, and the wave freezes once the request is latched, so a stuck line reads as a failure. For each rung, the block also publishes the peak value seen across all channels over a fixed number of strobes.

Top module: `loss_window_guard`

## Requirements
- R1: After reset, every `peak_o` field reads 0, both dump outputs start toggling, and every table limit holds the all-ones value.
- R2: With D = 2^LOG_D, rung k holds the sum of the most recent D^(k+1) samples. It is updated only on strobes whose count since reset is a multiple of D^k. Between those strobes it holds its value.
- R3: A rung sum never wraps. With the defaults, 64 samples of 255 give exactly 16320 on rung 2.
- R4: `peak_o` field k (bits k*SUM_W upward) is updated on every PEAK_LEN-th strobe and holds between updates. It receives the largest rung-k value, across all channels, taken just after each strobe of the period that ends there.
- R5: A channel trips when any of its rung sums is greater than or equal to the limit for that channel, that rung and the present `energy_i`. A limit of 40 trips on a sum of 40, and a limit of 41 does not.
- R6: A trip on any channel latches the unmaskable request, whatever the mask says.
- R7: Bit c of the mask (written from `mask_data_i` when `mask_we_i` is high) suppresses only the maskable request of channel c.
- R8: A latched request stays set until reset, even after the sums fall back to zero.
- R9: While its request is clear, a dump output inverts every DIV cycles. Once the request is latched, that output holds its level.
- R10: A limit write with `thr_we_i` high stores `thr_data_i` at (`thr_ch_i`, `thr_energy_i`, `thr_win_i`). Writes with a channel or rung index out of range are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | New-sample strobe, one cycle |
| sample_i | input | NUM_CH*SAMPLE_W | Samples, channel c at bits c*SAMPLE_W upward |
| energy_i | input | ENERGY_W | Beam-energy index for limit lookup |
| thr_we_i | input | 1 | Limit write enable |
| thr_ch_i | input | CH_W | Limit write channel |
| thr_energy_i | input | ENERGY_W | Limit write energy index |
| thr_win_i | input | WIN_W | Limit write rung |
| thr_data_i | input | SUM_W | Limit write value |
| mask_we_i | input | 1 | Mask write enable |
| mask_data_i | input | NUM_CH | Mask value, 1 = channel masked |
| dump_mask_o | output | 1 | Maskable request as a square wave, frozen on dump |
| dump_unmask_o | output | 1 | Unmaskable request as a square wave, frozen on dump |
| peak_o | output | NUM_WIN*SUM_W | Per-rung peak over the last period |

## Verification
A corrupted shift-register entry or rung accumulator shows up in `peak_o` at the next period boundary. It can also trip a dump against a limit set just above the expected sum, in which case the dump wave freezes within DIV cycles of the following strobe. A lost or extra boundary pulse shows up on the long rungs first: their published peak departs from the sum of the last D^(k+1) samples. A wrong latch or mask path shows up as a wave that keeps toggling when it should hold, or that holds when it should toggle, and that difference is visible within one oscillator period.

// File: rtl/loss_window_pkg.sv
package loss_window_pkg;
  function automatic longint win_len(input int log_d, input int k);
    return longint'(1) << (log_d * (k + 1));
  endfunction
endpackage

// File: rtl/rsum_lane.sv
module rsum_lane #(
  parameter int SAMPLE_W = 8,
  parameter int NUM_WIN  = 3,
  parameter int LOG_D    = 2,
  parameter int SUM_W    = SAMPLE_W + LOG_D * NUM_WIN
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic [NUM_WIN-1:0]       bnd_i,
  input  logic [SAMPLE_W-1:0]      sample_i,
  output logic [NUM_WIN*SUM_W-1:0] sum_o,
  output logic [NUM_WIN*SUM_W-1:0] sum_d_o
);
  localparam int D = 1 << LOG_D;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_lvl
    logic [SUM_W-1:0] in_w, nxt_w, acc_q;
    logic [SUM_W-1:0] sr_q [D];
    logic             upd;

    if (k == 0) begin : g_head
      assign in_w = {{(SUM_W-SAMPLE_W){1'b0}}, sample_i};
    end else begin : g_link
      // rung k eats the freshly completed total of rung k-1
      assign in_w = g_lvl[k-1].nxt_w;
    end

    assign upd   = strobe_i && bnd_i[k];
    assign nxt_w = acc_q + in_w - sr_q[D-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= '0;
        for (int i = 0; i < D; i++) sr_q[i] <= '0;
      end else if (upd) begin
        acc_q   <= nxt_w;
        sr_q[0] <= in_w;
        for (int i = 1; i < D; i++) sr_q[i] <= sr_q[i-1];
      end
    end

    assign sum_o[k*SUM_W +: SUM_W]   = acc_q;
    assign sum_d_o[k*SUM_W +: SUM_W] = upd ? nxt_w : acc_q;
  end
endmodule

// File: rtl/thr_table.sv
module thr_table #(
  parameter int NUM_CH   = 2,
  parameter int NUM_WIN  = 3,
  parameter int ENERGY_W = 2,
  parameter int SUM_W    = 14,
  parameter int CH_W     = 1,
  parameter int WIN_W    = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [CH_W-1:0]                 ch_i,
  input  logic [ENERGY_W-1:0]             en_i,
  input  logic [WIN_W-1:0]                win_i,
  input  logic [SUM_W-1:0]                data_i,
  input  logic [ENERGY_W-1:0]             energy_i,
  output logic [NUM_CH*NUM_WIN*SUM_W-1:0] thr_o
);
  localparam int N_E = 1 << ENERGY_W;

  logic [SUM_W-1:0] tab_q [NUM_CH][N_E][NUM_WIN];
  logic             wr_ok;

  assign wr_ok = we_i && (int'(ch_i) < NUM_CH) && (int'(win_i) < NUM_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CH; c++)
        for (int e = 0; e < N_E; e++)
          for (int w = 0; w < NUM_WIN; w++) tab_q[c][e][w] <= '1;
    end else if (wr_ok) begin
      tab_q[ch_i][en_i][win_i] <= data_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
      assign thr_o[(c*NUM_WIN+w)*SUM_W +: SUM_W] = tab_q[c][energy_i][w];
    end
  end
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int NUM_CH   = 2,
  parameter int NUM_WIN  = 3,
  parameter int SUM_W    = 14,
  parameter int PEAK_LEN = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            strobe_i,
  input  logic [NUM_CH*NUM_WIN*SUM_W-1:0] sum_d_i,
  output logic [NUM_WIN*SUM_W-1:0]        peak_o
);
  localparam int PC_W = (PEAK_LEN > 1) ? $clog2(PEAK_LEN) : 1;

  logic [PC_W-1:0]  pcnt_q;
  logic [SUM_W-1:0] cur [NUM_WIN];
  logic [SUM_W-1:0] acc_q [NUM_WIN];
  logic [SUM_W-1:0] pk_q [NUM_WIN];
  logic             last;

  assign last = (int'(pcnt_q) == PEAK_LEN - 1);

  always_comb begin
    for (int w = 0; w < NUM_WIN; w++) begin
      cur[w] = acc_q[w];
      for (int c = 0; c < NUM_CH; c++)
        if (sum_d_i[(c*NUM_WIN+w)*SUM_W +: SUM_W] > cur[w])
          cur[w] = sum_d_i[(c*NUM_WIN+w)*SUM_W +: SUM_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      for (int w = 0; w < NUM_WIN; w++) begin
        acc_q[w] <= '0;
        pk_q[w]  <= '0;
      end
    end else if (strobe_i) begin
      pcnt_q <= last ? '0 : pcnt_q + 1'b1;
      for (int w = 0; w < NUM_WIN; w++) begin
        acc_q[w] <= last ? '0 : cur[w];
        if (last) pk_q[w] <= cur[w];
      end
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_out
    assign peak_o[w*SUM_W +: SUM_W] = pk_q[w];
  end
endmodule

// File: rtl/dump_osc.sv
module dump_osc #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic wave_o
);
  localparam int DC_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DC_W-1:0] dcnt_q;
  logic            wrap;

  assign wrap = (int'(dcnt_q) == DIV - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      wave_o <= 1'b0;
    end else begin
      dcnt_q <= wrap ? '0 : dcnt_q + 1'b1;
      if (wrap && !hold_i) wave_o <= ~wave_o;
    end
  end
endmodule

// File: rtl/loss_window_guard.sv
module loss_window_guard #(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 8,
  parameter int NUM_WIN  = 3,
  parameter int LOG_D    = 2,
  parameter int ENERGY_W = 2,
  parameter int PEAK_LEN = 16,
  parameter int DIV      = 4,
  parameter int SUM_W    = SAMPLE_W + LOG_D * NUM_WIN,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  input  logic [ENERGY_W-1:0]        energy_i,
  input  logic                       thr_we_i,
  input  logic [CH_W-1:0]            thr_ch_i,
  input  logic [ENERGY_W-1:0]        thr_energy_i,
  input  logic [WIN_W-1:0]           thr_win_i,
  input  logic [SUM_W-1:0]           thr_data_i,
  input  logic                       mask_we_i,
  input  logic [NUM_CH-1:0]          mask_data_i,
  output logic                       dump_mask_o,
  output logic                       dump_unmask_o,
  output logic [NUM_WIN*SUM_W-1:0]   peak_o
);
  localparam int CNT_W = LOG_D * (NUM_WIN - 1);
  localparam int ALL_W = NUM_CH * NUM_WIN * SUM_W;

  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic [NUM_WIN-1:0] bnd;
  logic [ALL_W-1:0]   sum_all, sum_d_all, thr_all;
  logic [NUM_CH-1:0]  mask_q, trip;
  logic               dump_mask_q, dump_unmask_q;

  assign cnt_nx = cnt_q + 1'b1;
  assign bnd[0] = 1'b1;
  for (genvar k = 1; k < NUM_WIN; k++) begin : g_bnd
    assign bnd[k] = (cnt_nx[LOG_D*k-1:0] == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (strobe_i) cnt_q <= cnt_nx;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [NUM_WIN-1:0] hit;
    rsum_lane #(
      .SAMPLE_W(SAMPLE_W), .NUM_WIN(NUM_WIN), .LOG_D(LOG_D), .SUM_W(SUM_W)
    ) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_i),
      .bnd_i    (bnd),
      .sample_i (sample_i[c*SAMPLE_W +: SAMPLE_W]),
      .sum_o    (sum_all[c*NUM_WIN*SUM_W +: NUM_WIN*SUM_W]),
      .sum_d_o  (sum_d_all[c*NUM_WIN*SUM_W +: NUM_WIN*SUM_W])
    );
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      assign hit[w] = sum_all[(c*NUM_WIN+w)*SUM_W +: SUM_W] >=
                      thr_all[(c*NUM_WIN+w)*SUM_W +: SUM_W];
    end
    assign trip[c] = |hit;
  end

  thr_table #(
    .NUM_CH(NUM_CH), .NUM_WIN(NUM_WIN), .ENERGY_W(ENERGY_W),
    .SUM_W(SUM_W), .CH_W(CH_W), .WIN_W(WIN_W)
  ) u_thr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (thr_we_i),
    .ch_i     (thr_ch_i),
    .en_i     (thr_energy_i),
    .win_i    (thr_win_i),
    .data_i   (thr_data_i),
    .energy_i (energy_i),
    .thr_o    (thr_all)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q        <= '0;
      dump_mask_q   <= 1'b0;
      dump_unmask_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_data_i;
      dump_unmask_q <= dump_unmask_q | (|trip);
      dump_mask_q   <= dump_mask_q | (|(trip & ~mask_q));
    end
  end

  peak_hold #(
    .NUM_CH(NUM_CH), .NUM_WIN(NUM_WIN), .SUM_W(SUM_W), .PEAK_LEN(PEAK_LEN)
  ) u_peak (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .sum_d_i  (sum_d_all),
    .peak_o   (peak_o)
  );

  dump_osc #(.DIV(DIV)) u_osc_mask (
    .clk_i (clk_i), .rst_ni (rst_ni), .hold_i (dump_mask_q), .wave_o (dump_mask_o)
  );

  dump_osc #(.DIV(DIV)) u_osc_unmask (
    .clk_i (clk_i), .rst_ni (rst_ni), .hold_i (dump_unmask_q), .wave_o (dump_unmask_o)
  );
endmodule

// File: rtl/loss_window_guard_chk.sv
module loss_window_guard_chk #(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 8,
  parameter int NUM_WIN  = 3,
  parameter int LOG_D    = 2,
  parameter int SUM_W    = 14
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            strobe_i,
  input logic                            dump_mask_q,
  input logic                            dump_unmask_q,
  input logic                            dump_mask_o,
  input logic                            dump_unmask_o,
  input logic [NUM_WIN*SUM_W-1:0]        peak_o,
  input logic [NUM_CH*NUM_WIN*SUM_W-1:0] sum_all
);
  import loss_window_pkg::*;

  a_r8_unmask_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_unmask_q |=> dump_unmask_q);

  a_r8_mask_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_mask_q |=> dump_mask_q);

  a_r7_mask_within_unmask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_mask_q |-> dump_unmask_q);

  a_r9_wave_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_unmask_q && $past(dump_unmask_q)) |-> $stable(dump_unmask_o));

  a_r4_peak_only_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(strobe_i) |-> $stable(peak_o));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
      localparam longint LIM = ((longint'(1) << SAMPLE_W) - 1) * win_len(LOG_D, w);
      a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        longint'(sum_all[(c*NUM_WIN+w)*SUM_W +: SUM_W]) <= LIM);
    end
  end
endmodule

bind loss_window_guard loss_window_guard_chk #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .NUM_WIN(NUM_WIN), .LOG_D(LOG_D), .SUM_W(SUM_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .strobe_i      (strobe_i),
  .dump_mask_q   (dump_mask_q),
  .dump_unmask_q (dump_unmask_q),
  .dump_mask_o   (dump_mask_o),
  .dump_unmask_o (dump_unmask_o),
  .peak_o        (peak_o),
  .sum_all       (sum_all)
);

// File: tb/loss_window_guard_test.sv
module loss_window_guard_test;
  localparam int NCH = 2, SW = 8, NW = 3, LD = 2, EW = 2, PL = 16, DV = 4;
  localparam int SUMW = SW + LD * NW;

  // stimulus rows: {ch1 sample, ch0 sample}
  localparam logic [15:0] STIM [32] = '{
    16'h0301, 16'h0502, 16'h0104, 16'h0907, 16'h0000, 16'h2010, 16'h0A0B, 16'h0C01,
    16'h0102, 16'h0203, 16'h0304, 16'h0405, 16'h3000, 16'h0030, 16'h1111, 16'h0102,
    16'h4001, 16'h0140, 16'h0000, 16'h0000, 16'h0505, 16'h0606, 16'h0707, 16'h0808,
    16'h0F00, 16'h000F, 16'h2222, 16'h0103, 16'h0301, 16'h1001, 16'h0110, 16'h0909
  };

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0;
  logic [NCH*SW-1:0] sample = '0;
  logic [EW-1:0] energy = '0, thr_en = '0;
  logic thr_we = 1'b0, mask_we = 1'b0;
  logic [0:0] thr_ch = '0;
  logic [1:0] thr_win = '0;
  logic [SUMW-1:0] thr_data = '0;
  logic [NCH-1:0] mask_data = '0;
  logic dmask, dunm;
  logic [NW*SUMW-1:0] peak;

  int n_chk = 0, n_fail = 0, n = 0;
  int hist [NCH][256];
  int pk [NW];
  int pub [NW];
  bit done = 0;

  always #5ns clk = ~clk;

  loss_window_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .sample_i(sample), .energy_i(energy),
    .thr_we_i(thr_we), .thr_ch_i(thr_ch), .thr_energy_i(thr_en), .thr_win_i(thr_win),
    .thr_data_i(thr_data), .mask_we_i(mask_we), .mask_data_i(mask_data),
    .dump_mask_o(dmask), .dump_unmask_o(dunm), .peak_o(peak)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sum(input int ch, input int k);
    int len = 1 << (LD * (k + 1));
    int st  = 1 << (LD * k);
    int m   = n - (n % st);
    int s   = 0;
    for (int i = m - len + 1; i <= m; i++) if (i >= 1) s += hist[ch][i];
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    strobe = 1'b0; energy = '0; mask_we = 1'b0; thr_we = 1'b0;
    n = 0;
    for (int w = 0; w < NW; w++) begin pk[w] = 0; pub[w] = 0; end
    for (int c = 0; c < NCH; c++) for (int i = 0; i < 256; i++) hist[c][i] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_strobe(input int a, input int b);
    @(negedge clk);
    sample = {b[SW-1:0], a[SW-1:0]};
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    n++;
    hist[0][n] = a;
    hist[1][n] = b;
    for (int w = 0; w < NW; w++) begin
      for (int c = 0; c < NCH; c++) if (exp_sum(c, w) > pk[w]) pk[w] = exp_sum(c, w);
      if (n % PL == 0) begin pub[w] = pk[w]; pk[w] = 0; end
    end
  endtask

  task automatic check_peaks(input string req);
    for (int w = 0; w < NW; w++) check(req, peak[w*SUMW +: SUMW], pub[w]);
  endtask

  // counts inversions over 3*DIV cycles; healthy expects >= 2, dumped expects 0
  task automatic check_wave(input string req, input bit which_unm, input bit healthy);
    int tog = 0;
    logic prev = which_unm ? dunm : dmask;
    for (int i = 0; i < 3 * DV; i++) begin
      @(negedge clk);
      if ((which_unm ? dunm : dmask) != prev) tog++;
      prev = which_unm ? dunm : dmask;
    end
    check(req, (tog >= 2) ? 1 : 0, healthy ? 1 : 0);
  endtask

  task automatic write_thr(input int ch, input int en, input int win, input int val);
    @(negedge clk);
    thr_we = 1'b1; thr_ch = ch[0:0]; thr_en = en[EW-1:0]; thr_win = win[1:0];
    thr_data = val[SUMW-1:0];
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic write_mask(input int m);
    @(negedge clk);
    mask_we = 1'b1; mask_data = m[NCH-1:0];
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    check_peaks("R1 reset peak");
    check_wave("R1 R9 unmask toggles after reset", 1'b1, 1'b1);
    check_wave("R1 R9 mask toggles after reset", 1'b0, 1'b1);

    // R2 R4: table walk, all limits at reset value
    for (int i = 0; i < 32; i++) begin
      do_strobe(int'(STIM[i][7:0]), int'(STIM[i][15:8]));
      if (n % PL == 0) check_peaks("R2 R4 peak after period");
    end
    check_wave("R1 reset limits give no trip", 1'b1, 1'b1);

    // R4: peak holds between period ends
    do_strobe(200, 200);
    check_peaks("R4 peak holds mid-period");

    // R3: full-scale input never wraps
    do_reset();
    for (int i = 0; i < 64; i++) do_strobe(255, 255);
    check("R3 top rung full scale", peak[2*SUMW +: SUMW], 16320);
    check_peaks("R3 R4 full scale peaks");

    // R5: limit one above the sum does not trip
    do_reset();
    write_thr(1, 2, 0, 41);
    energy = 2'd2;
    for (int i = 0; i < 4; i++) do_strobe(0, 10);
    check_wave("R5 sum below limit", 1'b1, 1'b1);

    // R5 R6 R7 R8 R10: equal trips, energy selects the entry
    do_reset();
    write_thr(1, 2, 0, 40);
    write_thr(1, 2, 3, 1);   // R10: rung index out of range, dropped
    energy = 2'd1;
    for (int i = 0; i < 4; i++) do_strobe(0, 10);
    check_wave("R5 R10 other energy entry untouched", 1'b1, 1'b1);
    energy = 2'd2;
    repeat (2) @(negedge clk);
    check_wave("R5 R6 equal sum trips unmaskable", 1'b1, 1'b0);
    check_wave("R7 unmasked channel trips maskable", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) do_strobe(0, 0);
    check_wave("R8 request stays after sums drop", 1'b1, 1'b0);

    // R6 R7: masked channel only raises unmaskable
    do_reset();
    write_thr(1, 2, 0, 40);
    write_mask(2);
    energy = 2'd2;
    for (int i = 0; i < 4; i++) do_strobe(0, 10);
    repeat (2) @(negedge clk);
    check_wave("R6 masked channel still unmaskable", 1'b1, 1'b0);
    check_wave("R7 mask suppresses maskable", 1'b0, 1'b1);

    // R2: long rung trips only at its boundary (16 samples of 1 -> 16)
    do_reset();
    write_thr(0, 0, 1, 16);
    for (int i = 0; i < 15; i++) do_strobe(1, 0);
    check_wave("R2 long rung not yet updated", 1'b1, 1'b1);
    do_strobe(1, 0);
    repeat (2) @(negedge clk);
    check_wave("R2 long rung reaches limit at boundary", 1'b1, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule